// File: doc/BRIEF.md
# Dual-Rail Bit-Serial Adder

This block adds two binary words one bit per beat, least significant bit first. Every value it handles is a complementary pair: a true rail and a false rail. This covers the two operand bits, the sum bit and the carry it keeps between beats. A pair is written `{true, false}` on a 2-bit port, so `2'b10` means logic one and `2'b01` means logic zero. `2'b00` and `2'b11` are malformed.

The combinational step is a two-plane logic array made only of two-input OR and NOR gates.

- The first plane forms every one of the eight minterms of (x, y, carry), two copies of each. Each minterm ORs the complemented literals and inverts the result with a NOR.
- The second plane ORs four minterms into each of sum, not-sum, carry and not-carry.

Operand beats enter on a valid/ready input stream, and sum beats leave on a valid/ready output stream that holds one beat.

- **Input acceptance:** the input is accepted whenever the output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`.
- **Output stall:** while `out_valid` is high and `out_ready` is low, the sum beat stays frozen.
- **Word start:** a plain `start` pulse resets the carry to zero. A beat accepted in the same cycle as `start` is treated as the least significant bit of a new word.
- **Malformed beats:** a beat with a malformed operand pair is consumed but produces no sum. It leaves the carry as it was and raises `rail_err` for one cycle.

Top module: `dra_serial_adder`

## Requirements
- R1: After reset, `carry` is `2'b01` (zero), `out_valid` is 0 and `rail_err` is 0.
- R2: For an accepted well-formed beat, the next output beat has sum true rail = x XOR y XOR c, where c is the carry in use. `out_z` is `{sum, ~sum}`.
- R3: An accepted well-formed beat sets `carry` on the next cycle to `{m, ~m}`, where m is the majority of x, y and c.
- R4: When `start` is high, the carry in use for that cycle is zero. If no well-formed beat is accepted in that cycle, `carry` becomes `2'b01` on the next cycle.
- R5: An accepted beat where `in_x` or `in_y` is `2'b00` or `2'b11` makes `rail_err` 1 for exactly the next cycle. It creates no output beat and leaves `carry` unchanged, unless `start` clears it.
- R6: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_z` stays stable on the next cycle.
- R7: Exactly one output beat is produced per accepted well-formed input beat, in acceptance order. `out_valid` is high from the cycle after acceptance until the beat is taken.
- R8: Whenever `out_valid` is high, `out_z` is a well-formed pair. `carry` is a well-formed pair at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears carry; beat in same cycle is a word's LSB |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Operand beat can be taken |
| in_x | input | 2 | Operand x as {true, false} |
| in_y | input | 2 | Operand y as {true, false} |
| out_valid | output | 1 | Sum beat present |
| out_ready | input | 1 | Consumer takes the sum beat |
| out_z | output | 2 | Sum as {true, false} |
| carry | output | 2 | Carry state as {true, false} |
| rail_err | output | 1 | One-cycle pulse after a malformed beat was consumed |

## Verification
The in-module assertions check the following on every cycle:
- the complementary form of `out_z` and `carry`;
- the frozen output under back-pressure;
- the carry reset after a lone `start`;
- the untouched carry and the error pulse after a malformed beat.

The arithmetic itself is shown only by the bench's scenarios. These are carry propagation across multi-bit words, all eight operand/carry combinations, `start` coinciding with a beat, and the one-to-one ordering of sum beats against accepted inputs under random stalls.

// File: rtl/dra_pkg.sv
package dra_pkg;
  localparam int RAIL_W   = 2;
  localparam int VARS     = 3;
  localparam int MINTERMS = 1 << VARS;
  localparam int COPIES   = 2;
  localparam logic [RAIL_W-1:0] RAIL_ZERO = 2'b01;
  localparam logic [RAIL_W-1:0] RAIL_ONE  = 2'b10;
  // Onset masks, index = {x, y, c}
  localparam logic [MINTERMS-1:0] SUM_ONSET   = 8'b1001_0110;
  localparam logic [MINTERMS-1:0] CARRY_ONSET = 8'b1110_1000;

  function automatic logic rail_ok(input logic [RAIL_W-1:0] p);
    return p[1] != p[0];
  endfunction
endpackage

// File: rtl/dra_and_plane.sv
module dra_and_plane
  import dra_pkg::*;
(
  input  logic [RAIL_W-1:0] x,
  input  logic [RAIL_W-1:0] y,
  input  logic [RAIL_W-1:0] c,
  output logic [COPIES-1:0][MINTERMS-1:0] terms
);
  for (genvar m = 0; m < MINTERMS; m++) begin : g_term
    // complemented literal: minterm wants 1 -> use false rail
    localparam bit WX = m[2];
    localparam bit WY = m[1];
    localparam bit WC = m[0];
    for (genvar k = 0; k < COPIES; k++) begin : g_copy
      logic lx, ly, lc, or_xy;
      assign lx = WX ? x[0] : x[1];
      assign ly = WY ? y[0] : y[1];
      assign lc = WC ? c[0] : c[1];
      assign or_xy = lx | ly;
      assign terms[k][m] = ~(or_xy | lc);
    end
  end
endmodule

// File: rtl/dra_or_plane.sv
module dra_or_plane
  import dra_pkg::*;
#(
  parameter logic [MINTERMS-1:0] ONSET = SUM_ONSET
) (
  input  logic [MINTERMS-1:0] terms,
  output logic [RAIL_W-1:0]   f
);
  localparam int GROUP = MINTERMS / 2;

  function automatic int pick(input logic [MINTERMS-1:0] msk, input bit want, input int k);
    int cnt;
    int idx;
    cnt = 0;
    idx = 0;
    for (int i = 0; i < MINTERMS; i++) begin
      if (msk[i] == want) begin
        if (cnt == k) idx = i;
        cnt++;
      end
    end
    return idx;
  endfunction

  // rail 1 collects the onset, rail 0 the offset
  for (genvar r = 0; r < RAIL_W; r++) begin : g_rail
    localparam bit WANT = (r == 1);
    localparam int I0 = pick(ONSET, WANT, 0);
    localparam int I1 = pick(ONSET, WANT, 1);
    localparam int I2 = pick(ONSET, WANT, 2);
    localparam int I3 = pick(ONSET, WANT, 3);
    logic a0, a1, n2;
    assign a0   = terms[I0] | terms[I1];
    assign a1   = terms[I2] | terms[I3];
    assign n2   = ~(a0 | a1);
    assign f[r] = ~(n2 | n2);
  end
endmodule

// File: rtl/dra_out_stage.sv
module dra_out_stage
  import dra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RAIL_W-1:0] z_next,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [RAIL_W-1:0] out_z
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_z     <= RAIL_ZERO;
    end else if (load) begin
      out_valid <= 1'b1;
      out_z     <= z_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_z));
  p_out_rails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_z[1] != out_z[0]);
endmodule

// File: rtl/dra_serial_adder.sv
module dra_serial_adder
  import dra_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_x,
  input  logic [1:0] in_y,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_z,
  output logic [1:0] carry,
  output logic       rail_err
);
  logic [RAIL_W-1:0] carry_q, c_use, z_next, c_next;
  logic [COPIES-1:0][MINTERMS-1:0] terms;
  logic fire, bad, good;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign bad      = !rail_ok(in_x) || !rail_ok(in_y);
  assign good     = fire && !bad;
  assign c_use    = start ? RAIL_ZERO : carry_q;
  assign carry    = carry_q;

  dra_and_plane u_and (.x(in_x), .y(in_y), .c(c_use), .terms(terms));

  dra_or_plane #(.ONSET(SUM_ONSET))   u_sum (.terms(terms[0]), .f(z_next));
  dra_or_plane #(.ONSET(CARRY_ONSET)) u_cry (.terms(terms[1]), .f(c_next));

  dra_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(good), .z_next(z_next),
    .out_ready(out_ready), .out_valid(out_valid), .out_z(out_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q  <= RAIL_ZERO;
      rail_err <= 1'b0;
    end else begin
      rail_err <= fire && bad;
      if (good)       carry_q <= c_next;
      else if (start) carry_q <= RAIL_ZERO;
    end
  end

  p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && !(in_valid && in_ready && rail_ok(in_x) && rail_ok(in_y)) |=> carry == 2'b01);
  p_bad_keeps_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !start && (in_x[1] == in_x[0] || in_y[1] == in_y[0])
    |=> $stable(carry) && rail_err);
  p_bad_no_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_x[1] == in_x[0] || in_y[1] == in_y[0]) && !out_valid
    |=> !out_valid);
  p_carry_rails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    carry[1] != carry[0]);
endmodule

// File: tb/dra_serial_adder_tb.sv
module dra_serial_adder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [1:0] in_x = 2'b01, in_y = 2'b01;
  logic in_ready, out_valid, rail_err;
  logic [1:0] out_z, carry;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit mc = 1'b0;
  logic [1:0] q[$];

  always #2 clk = ~clk;

  dra_serial_adder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_z(out_z), .carry(carry), .rail_err(rail_err)
  );

  function automatic logic [1:0] enc(input bit b);
    return b ? 2'b10 : 2'b01;
  endfunction
  function automatic bit ok_pair(input logic [1:0] p);
    return p[1] != p[0];
  endfunction
  function automatic bit ref_sum(input bit a, input bit b, input bit c);
    return a ^ b ^ c;
  endfunction
  function automatic bit ref_maj(input bit a, input bit b, input bit c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive after a falling edge, predict the next rising edge, check after the following falling edge.
  task automatic step(input bit st, input bit v, input logic [1:0] x, input logic [1:0] y, input bit rdy);
    bit infire, bad, cin, exp_err, held;
    logic [1:0] held_z;
    start = st; in_valid = v; in_x = x; in_y = y; out_ready = rdy;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R6 in_ready", in_ready, !out_valid || out_ready);
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk(1'b0, "R7 unexpected beat", out_z, 0);
      else begin
        chk(out_z == q[0], "R2 sum", out_z, q[0]);
        void'(q.pop_front());
      end
    end
    held = out_valid && !out_ready;
    held_z = out_z;
    infire = in_valid && in_ready;
    bad = !ok_pair(x) || !ok_pair(y);
    cin = st ? 1'b0 : mc;
    exp_err = infire && bad;
    if (infire && !bad) begin
      q.push_back(enc(ref_sum(x[1], y[1], cin)));
      mc = ref_maj(x[1], y[1], cin);
    end else if (st) mc = 1'b0;
    @(negedge clk);
    chk(carry == enc(mc), "R3/R4 carry", carry, enc(mc));
    chk(rail_err == exp_err, "R5 rail_err", rail_err, exp_err);
    chk(out_valid == (q.size() != 0), "R7 out_valid", out_valid, q.size() != 0);
    if (held) chk(out_z == held_z, "R6 hold", out_z, held_z);
    if (out_valid) chk(ok_pair(out_z), "R8 rails", out_z, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 2'b01, 2'b01, 1'b1);
  endtask

  initial begin
    int bits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(carry == 2'b01, "R1 carry", carry, 2'b01);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(rail_err == 1'b0, "R1 rail_err", rail_err, 0);
    @(negedge clk);

    // R2/R3: all eight operand/carry combinations
    for (int m = 0; m < 8; m++) begin
      step(1'b1, 1'b0, 2'b01, 2'b01, 1'b1);
      if (m[0]) step(1'b0, 1'b1, 2'b10, 2'b10, 1'b1); // make carry 1
      step(1'b0, 1'b1, enc(m[2]), enc(m[1]), 1'b1);
      drain();
    end
    // R3 long carry chain: 0xFF + 0x01 then propagation
    step(1'b1, 1'b1, 2'b10, 2'b10, 1'b1);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 2'b10, 2'b01, 1'b1);
    drain();
    // R4 start in same cycle as a beat with carry set
    step(1'b1, 1'b1, 2'b10, 2'b10, 1'b1);
    step(1'b1, 1'b1, 2'b10, 2'b01, 1'b1);
    drain();
    // R5 malformed pairs, with carry = 1, then a beat showing the carry kept
    step(1'b1, 1'b1, 2'b10, 2'b10, 1'b1);
    step(1'b0, 1'b1, 2'b00, 2'b01, 1'b1);
    step(1'b0, 1'b1, 2'b10, 2'b11, 1'b1);
    step(1'b0, 1'b1, 2'b01, 2'b01, 1'b1);
    step(1'b1, 1'b1, 2'b11, 2'b00, 1'b1); // start + malformed clears carry
    drain();
    // R6 stall: output held while not ready
    step(1'b1, 1'b1, 2'b10, 2'b01, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 2'b01, 2'b10, 1'b0);
    drain();

    // constrained random
    void'($urandom(32'd1234));
    bits = 0;
    for (int i = 0; i < 4000; i++) begin
      bit st, v, r, inv;
      logic [1:0] x, y;
      st = (bits >= 8) || ($urandom % 16 == 0);
      if (st) bits = 0;
      v = ($urandom % 4) != 0;
      r = ($urandom % 3) != 0;
      inv = ($urandom % 10) == 0;
      x = enc($urandom % 2);
      y = enc($urandom % 2);
      if (inv) begin
        if ($urandom % 2) x = ($urandom % 2) ? 2'b00 : 2'b11;
        else              y = ($urandom % 2) ? 2'b00 : 2'b11;
      end
      if (v && (!out_valid || r)) bits++;
      step(st, v, x, y, r);
    end
    drain();
    chk(q.size() == 0, "R7 leftover", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule